// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates virtual addresses to physical addresses through a fully associative table. Each table entry covers an aligned pair of neighbouring pages: it holds one virtual page tag, an address-space identifier (ASID) and a page-size mask, plus two low records. One record serves the even page of the pair and the other serves the odd page. The page size of each entry is set by its mask and ranges from 4 KB to 16 MB. A low record supplies the physical frame number, a cache attribute and the permission bits that gate each kind of access.

A requester presents a virtual address, its current ASID and an access kind on the lookup port. It receives the physical address, the cache attribute and a fault code. A one-entry last-hit register on the lookup port answers repeated accesses to the same entry one cycle earlier than a full-table search. One window of the address space bypasses the table entirely. A management port reads entries by index, writes them by index, or writes them into a victim slot picked by a free-running counter. Every management operation returns the previous contents of the slot it touched.

Top module: `paired_tlb`

## Requirements
- R1: While reset is high and in the cycle after it, `rs_valid` and `mg_rvalid` are low and `lk_ready` is high. Every entry is cleared to unused, so any mapped lookup misses.
- R2: An entry hits when it has been written and VA[31:13] equals its tag on every bit that the mask does not cover (mask bit i covers VA bit 13+i). Its ASID must also equal the requester's ASID. A lookup that hits no entry returns fault code 1 (miss), with `rs_pa` zero and `rs_multi` low.
- R3: An entry whose two low records both have the global bit set hits under any ASID. If only one of the two global bits is set, the ASID must match.
- R4: The record is picked by VA bit 13+k, where k is the highest set mask bit, or by VA bit 12 when the mask is zero; a one picks the odd record. The physical address is {pfn, 12'b0} with the bits under {mask, 12'hFFF} taken from the VA.
- R5: A hit on a record whose valid bit is clear returns fault code 2 (invalid). This check has priority over all permission faults.
- R6: A store (access 1) or capability store (access 3) that hits a record whose dirty bit is clear returns fault code 3 (modify).
- R7: A capability load (access 2) that hits a record with the no-capability-load bit set returns fault code 4. A capability store that hits a dirty record with the no-capability-store bit set returns fault code 5. Plain loads (access 0) and stores are unaffected by these bits.
- R8: A VA with bits [31:29] = 3'b100 bypasses the table. It returns PA = VA[28:0] zero-extended, cache attribute 2 and fault code 0, one cycle after acceptance, whatever the access kind and table contents.
- R9: A lookup that hits the last-hit register responds one cycle after acceptance. Any other mapped lookup takes two cycles, and `lk_ready` is low during the search cycle.
- R10: Any table write empties the last-hit register, so the next mapped lookup takes the two-cycle path.
- R11: When several entries hit, the lowest-indexed one supplies the result and `rs_multi` is high. Such a result is never loaded into the last-hit register.
- R12: Management ops (0 read, 1 indexed write, 2 random write) respond one cycle later. The response carries the index used and the slot's previous tag, ASID, mask and both records. The record layout is {ncs[35], ncl[34], pfn[33:6], ca[5:3], dirty[2], valid[1], global[0]}.
- R13: A random write picks a victim index in [`cfg_wired`, entries-1] from a free-running down-counter. It returns the victim's previous contents and stores the new entry there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup port can accept a request |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 8 | Requester ASID |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 cap load, 3 cap store |
| rs_valid | output | 1 | Lookup result valid (one cycle) |
| rs_pa | output | 40 | Physical address |
| rs_ca | output | 3 | Cache attribute |
| rs_fault | output | 3 | Fault code: 0 none, 1 miss, 2 invalid, 3 modify, 4 cap load, 5 cap store |
| rs_multi | output | 1 | More than one entry hit |
| mg_valid | input | 1 | Management request present |
| mg_op | input | 2 | 0 read, 1 indexed write, 2 random write |
| mg_idx | input | 6 | Entry index for read and indexed write |
| mg_vpn | input | 19 | Tag to write |
| mg_asid | input | 8 | ASID to write |
| mg_mask | input | 12 | Page mask to write |
| mg_lo0 | input | 36 | Even-page record to write |
| mg_lo1 | input | 36 | Odd-page record to write |
| cfg_wired | input | 6 | Lowest index a random write may replace |
| mg_rvalid | output | 1 | Management response valid |
| mg_ridx | output | 6 | Index that was accessed |
| mg_rvpn | output | 19 | Previous tag |
| mg_rasid | output | 8 | Previous ASID |
| mg_rmask | output | 12 | Previous mask |
| mg_rlo0 | output | 36 | Previous even record |
| mg_rlo1 | output | 36 | Previous odd record |

## Verification
The bound checker watches several properties on every cycle. It checks the quiet outputs after reset and that every search cycle is followed by a result with the port ready again. It also checks the bypass translation of the unmapped window, the one-cycle management response with its echoed index, and that random victims stay inside the wired boundary. On any result, it checks that a miss carries a zero address and that a multi-hit flag never appears with a miss. Other behaviours depend on what the table holds, so only the bench's scenarios can show them. These are the tag, ASID and global matching, the even/odd record choice under different masks, the fault priority, the lowest-index choice on a multi-hit, and the change in latency when the last-hit register fills or a write empties it.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int PFN_W  = 28;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int ASID_W = 8;
    localparam int MASK_W = 12;
    localparam int VPN_W  = VA_W - OFF_W - 1;
    localparam int CA_W   = 3;

    localparam logic [2:0]      BYPASS_SEG = 3'b100;
    localparam logic [CA_W-1:0] BYPASS_CA  = 3'd2;

    typedef struct packed {
        logic             ncs;
        logic             ncl;
        logic [PFN_W-1:0] pfn;
        logic [CA_W-1:0]  ca;
        logic             d;
        logic             v;
        logic             g;
    } lo_t;

    localparam int LO_W = $bits(lo_t);

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [MASK_W-1:0] mask;
        lo_t               lo0;
        lo_t               lo1;
    } ent_t;

    typedef enum logic [1:0] {ACC_LD, ACC_ST, ACC_CLD, ACC_CST} acc_e;

    typedef enum logic [2:0] {
        FLT_NONE, FLT_MISS, FLT_INVAL, FLT_MOD, FLT_CLD, FLT_CST
    } flt_e;

    typedef enum logic [1:0] {MOP_READ, MOP_WIDX, MOP_WRAND, MOP_NOP} mop_e;

    // tag compare under the mask, with ASID unless both records are global
    function automatic logic ent_hit(ent_t e, logic used, logic [VA_W-1:0] va,
                                     logic [ASID_W-1:0] asid);
        logic [VPN_W-1:0] care;
        logic             tag_eq;
        logic             id_ok;
        care   = ~{{(VPN_W-MASK_W){1'b0}}, e.mask};
        tag_eq = (((va[VA_W-1:OFF_W+1] ^ e.vpn) & care) == '0);
        id_ok  = (e.lo0.g && e.lo1.g) || (asid == e.asid);
        return used && tag_eq && id_ok;
    endfunction

    // the VA bit just above the page offset picks the odd record
    function automatic logic odd_pick(logic [MASK_W-1:0] mask, logic [VA_W-1:0] va);
        logic s;
        s = va[OFF_W];
        for (int i = 0; i < MASK_W; i++) begin
            if (mask[i]) s = va[OFF_W+1+i];
        end
        return s;
    endfunction

    function automatic logic [PA_W-1:0] form_pa(lo_t r, logic [MASK_W-1:0] mask,
                                                logic [VA_W-1:0] va);
        logic [PA_W-1:0] offm;
        logic [PA_W-1:0] vx;
        offm = {{(PA_W-MASK_W-OFF_W){1'b0}}, mask, {OFF_W{1'b1}}};
        vx   = {{(PA_W-VA_W){1'b0}}, va};
        return ({r.pfn, {OFF_W{1'b0}}} & ~offm) | (vx & offm);
    endfunction

    // valid first, then dirty, then the capability inhibits
    function automatic flt_e perm_check(lo_t r, acc_e a);
        if (!r.v)                                  return FLT_INVAL;
        if ((a == ACC_ST || a == ACC_CST) && !r.d) return FLT_MOD;
        if (a == ACC_CLD && r.ncl)                 return FLT_CLD;
        if (a == ACC_CST && r.ncs)                 return FLT_CST;
        return FLT_NONE;
    endfunction

    function automatic logic [PA_W-1:0] bypass_pa(logic [VA_W-1:0] va);
        return {{(PA_W-VA_W+3){1'b0}}, va[VA_W-4:0]};
    endfunction

endpackage

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
    parameter int N  = 48,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] wired,
    output logic [IW-1:0] victim
);
    localparam logic [IW-1:0] TOP = IW'(N - 1);

    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= TOP;
        end else if (cnt <= wired || cnt == '0) begin
            cnt <= TOP;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // a boundary raised above the count takes effect at once
    assign victim = (cnt < wired) ? TOP : cnt;

endmodule

// File: rtl/ptlb_store.sv
module ptlb_store
    import ptlb_pkg::*;
#(
    parameter int N  = 48,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mg_valid,
    input  mop_e          mg_op,
    input  logic [IW-1:0] mg_idx,
    input  ent_t          mg_ent,
    input  logic [IW-1:0] victim,
    output ent_t          ents [N],
    output logic [N-1:0]  used,
    output logic          wr_pulse,
    output logic          r_valid,
    output logic [IW-1:0] r_idx,
    output ent_t          r_ent
);
    logic [IW-1:0] tgt;
    logic          in_rng;
    logic          do_wr;
    ent_t          old_ent;

    always_comb begin
        tgt     = (mg_op == MOP_WRAND) ? victim : mg_idx;
        in_rng  = ({1'b0, tgt} < (IW+1)'(N));
        do_wr   = mg_valid && in_rng && (mg_op == MOP_WIDX || mg_op == MOP_WRAND);
        old_ent = in_rng ? ents[tgt] : '0;
    end

    assign wr_pulse = do_wr;

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i] <= '0;
                used[i] <= 1'b0;
            end else if (do_wr && tgt == IW'(i)) begin
                ents[i] <= mg_ent;
                used[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid <= 1'b0;
            r_idx   <= '0;
            r_ent   <= '0;
        end else begin
            r_valid <= mg_valid;
            if (mg_valid) begin
                r_idx <= tgt;
                r_ent <= old_ent;
            end
        end
    end

endmodule

// File: rtl/ptlb_lookup.sv
module ptlb_lookup
    import ptlb_pkg::*;
#(
    parameter int N  = 48,
    parameter int IW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  acc_e              lk_acc,
    output logic              lk_ready,
    input  ent_t              ents [N],
    input  logic [N-1:0]      used,
    input  logic              wr_pulse,
    output logic              rs_valid,
    output logic [PA_W-1:0]   rs_pa,
    output logic [CA_W-1:0]   rs_ca,
    output flt_e              rs_fault,
    output logic              rs_multi
);
    logic              busy;
    logic [VA_W-1:0]   h_va;
    logic [ASID_W-1:0] h_asid;
    acc_e              h_acc;
    logic              mv;
    logic [IW-1:0]     midx;

    logic [N-1:0]      hvec;
    logic [IW-1:0]     s_idx;
    logic              s_any;
    logic              s_multi;

    logic              bypass;
    logic              micro_hit;
    logic              accept;
    logic              fast;

    ent_t              sel_e;
    logic [VA_W-1:0]   sel_va;
    acc_e              sel_acc;
    lo_t               rec;
    logic [PA_W-1:0]   r_pa;
    flt_e              r_flt;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hvec[i] = ent_hit(ents[i], used[i], h_va, h_asid);
    end

    always_comb begin
        s_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hvec[i]) s_idx = IW'(i);
        end
        s_any   = |hvec;
        s_multi = |(hvec & (hvec - 1'b1));
    end

    assign lk_ready  = !busy;
    assign bypass    = (lk_va[VA_W-1:VA_W-3] == BYPASS_SEG);
    assign micro_hit = mv && ent_hit(ents[midx], used[midx], lk_va, lk_asid);
    assign accept    = lk_valid && !busy;
    assign fast      = accept && (bypass || micro_hit);

    always_comb begin
        sel_e   = busy ? ents[s_idx] : ents[midx];
        sel_va  = busy ? h_va : lk_va;
        sel_acc = busy ? h_acc : lk_acc;
        rec     = odd_pick(sel_e.mask, sel_va) ? sel_e.lo1 : sel_e.lo0;
        r_pa    = form_pa(rec, sel_e.mask, sel_va);
        r_flt   = perm_check(rec, sel_acc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            h_va     <= '0;
            h_asid   <= '0;
            h_acc    <= ACC_LD;
            rs_valid <= 1'b0;
            rs_pa    <= '0;
            rs_ca    <= '0;
            rs_fault <= FLT_NONE;
            rs_multi <= 1'b0;
        end else begin
            rs_valid <= busy || fast;
            if (busy) begin
                busy <= 1'b0;
                if (s_any) begin
                    rs_pa    <= r_pa;
                    rs_ca    <= rec.ca;
                    rs_fault <= r_flt;
                    rs_multi <= s_multi;
                end else begin
                    rs_pa    <= '0;
                    rs_ca    <= '0;
                    rs_fault <= FLT_MISS;
                    rs_multi <= 1'b0;
                end
            end else if (fast) begin
                rs_multi <= 1'b0;
                if (bypass) begin
                    rs_pa    <= bypass_pa(lk_va);
                    rs_ca    <= BYPASS_CA;
                    rs_fault <= FLT_NONE;
                end else begin
                    rs_pa    <= r_pa;
                    rs_ca    <= rec.ca;
                    rs_fault <= r_flt;
                end
            end else if (accept) begin
                busy   <= 1'b1;
                h_va   <= lk_va;
                h_asid <= lk_asid;
                h_acc  <= lk_acc;
            end
        end
    end

    // last-hit register: filled by a unique search hit, emptied by any write
    always_ff @(posedge clk) begin
        if (rst) begin
            mv   <= 1'b0;
            midx <= '0;
        end else if (wr_pulse) begin
            mv <= 1'b0;
        end else if (busy && s_any && !s_multi) begin
            mv   <= 1'b1;
            midx <= s_idx;
        end
    end

endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
    import ptlb_pkg::*;
#(
    parameter  int N_ENTRIES = 48,
    localparam int IW        = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    output logic              rs_valid,
    output logic [PA_W-1:0]   rs_pa,
    output logic [CA_W-1:0]   rs_ca,
    output logic [2:0]        rs_fault,
    output logic              rs_multi,
    input  logic              mg_valid,
    input  logic [1:0]        mg_op,
    input  logic [IW-1:0]     mg_idx,
    input  logic [VPN_W-1:0]  mg_vpn,
    input  logic [ASID_W-1:0] mg_asid,
    input  logic [MASK_W-1:0] mg_mask,
    input  logic [LO_W-1:0]   mg_lo0,
    input  logic [LO_W-1:0]   mg_lo1,
    input  logic [IW-1:0]     cfg_wired,
    output logic              mg_rvalid,
    output logic [IW-1:0]     mg_ridx,
    output logic [VPN_W-1:0]  mg_rvpn,
    output logic [ASID_W-1:0] mg_rasid,
    output logic [MASK_W-1:0] mg_rmask,
    output logic [LO_W-1:0]   mg_rlo0,
    output logic [LO_W-1:0]   mg_rlo1
);
    ent_t          ents [N_ENTRIES];
    logic [N_ENTRIES-1:0] used;
    logic          wr_pulse;
    logic [IW-1:0] victim;
    ent_t          w_ent;
    ent_t          r_ent;
    flt_e          flt;

    assign w_ent = '{vpn: mg_vpn, asid: mg_asid, mask: mg_mask,
                     lo0: lo_t'(mg_lo0), lo1: lo_t'(mg_lo1)};

    ptlb_victim #(.N(N_ENTRIES), .IW(IW)) u_victim (
        .clk    (clk),
        .rst    (rst),
        .wired  (cfg_wired),
        .victim (victim)
    );

    ptlb_store #(.N(N_ENTRIES), .IW(IW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .mg_valid (mg_valid),
        .mg_op    (mop_e'(mg_op)),
        .mg_idx   (mg_idx),
        .mg_ent   (w_ent),
        .victim   (victim),
        .ents     (ents),
        .used     (used),
        .wr_pulse (wr_pulse),
        .r_valid  (mg_rvalid),
        .r_idx    (mg_ridx),
        .r_ent    (r_ent)
    );

    ptlb_lookup #(.N(N_ENTRIES), .IW(IW)) u_lookup (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .lk_va    (lk_va),
        .lk_asid  (lk_asid),
        .lk_acc   (acc_e'(lk_acc)),
        .lk_ready (lk_ready),
        .ents     (ents),
        .used     (used),
        .wr_pulse (wr_pulse),
        .rs_valid (rs_valid),
        .rs_pa    (rs_pa),
        .rs_ca    (rs_ca),
        .rs_fault (flt),
        .rs_multi (rs_multi)
    );

    assign rs_fault = flt;
    assign mg_rvpn  = r_ent.vpn;
    assign mg_rasid = r_ent.asid;
    assign mg_rmask = r_ent.mask;
    assign mg_rlo0  = r_ent.lo0;
    assign mg_rlo1  = r_ent.lo1;

endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk
    import ptlb_pkg::*;
#(
    parameter  int N_ENTRIES = 48,
    localparam int IW        = $clog2(N_ENTRIES)
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              lk_ready,
    input logic [VA_W-1:0]   lk_va,
    input logic              rs_valid,
    input logic [PA_W-1:0]   rs_pa,
    input logic [2:0]        rs_fault,
    input logic              rs_multi,
    input logic              mg_valid,
    input logic [1:0]        mg_op,
    input logic [IW-1:0]     mg_idx,
    input logic [IW-1:0]     cfg_wired,
    input logic              mg_rvalid,
    input logic [IW-1:0]     mg_ridx
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rs_valid && !mg_rvalid && lk_ready));

    // R2
    miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_fault == 3'(FLT_MISS)) |-> (rs_pa == '0 && !rs_multi));

    // R8
    bypass_xlate_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready && lk_va[VA_W-1:VA_W-3] == BYPASS_SEG)
        |=> (rs_valid && rs_fault == 3'(FLT_NONE)
             && rs_pa == {{(PA_W-VA_W+3){1'b0}}, $past(lk_va[VA_W-4:0])}));

    // R9
    search_done_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_ready |=> (rs_valid && lk_ready));

    // R11
    multi_not_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_multi) |-> (rs_fault != 3'(FLT_MISS)));

    // R12
    mgmt_echo_chk: assert property (@(posedge clk) disable iff (rst)
        (mg_valid && mg_op != 2'(MOP_WRAND)) |=> (mg_rvalid && mg_ridx == $past(mg_idx)));

    // R13
    victim_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mg_valid && mg_op == 2'(MOP_WRAND) && ({1'b0, cfg_wired} < (IW+1)'(N_ENTRIES)))
        |=> (mg_rvalid && mg_ridx >= $past(cfg_wired)
             && ({1'b0, mg_ridx} < (IW+1)'(N_ENTRIES))));

endmodule

bind paired_tlb ptlb_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .lk_va     (lk_va),
    .rs_valid  (rs_valid),
    .rs_pa     (rs_pa),
    .rs_fault  (rs_fault),
    .rs_multi  (rs_multi),
    .mg_valid  (mg_valid),
    .mg_op     (mg_op),
    .mg_idx    (mg_idx),
    .cfg_wired (cfg_wired),
    .mg_rvalid (mg_rvalid),
    .mg_ridx   (mg_ridx)
);

// File: tb/paired_tlb_tb.sv
module paired_tlb_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_acc = '0;
    logic        rs_valid;
    logic [39:0] rs_pa;
    logic [2:0]  rs_ca;
    logic [2:0]  rs_fault;
    logic        rs_multi;
    logic        mg_valid = 1'b0;
    logic [1:0]  mg_op = '0;
    logic [5:0]  mg_idx = '0;
    logic [18:0] mg_vpn = '0;
    logic [7:0]  mg_asid = '0;
    logic [11:0] mg_mask = '0;
    logic [35:0] mg_lo0 = '0;
    logic [35:0] mg_lo1 = '0;
    logic [5:0]  cfg_wired = '0;
    logic        mg_rvalid;
    logic [5:0]  mg_ridx;
    logic [18:0] mg_rvpn;
    logic [7:0]  mg_rasid;
    logic [11:0] mg_rmask;
    logic [35:0] mg_rlo0;
    logic [35:0] mg_rlo1;

    int total = 0;
    int bad = 0;

    logic [39:0] o_pa;
    logic [2:0]  o_ca;
    logic [2:0]  o_flt;
    logic        o_multi;
    int          o_lat;
    logic        o_rv;
    logic [5:0]  o_ridx;
    logic [18:0] o_rvpn;
    logic [7:0]  o_rasid;
    logic [11:0] o_rmask;
    logic [35:0] o_rlo0;
    logic [35:0] o_rlo1;
    logic [18:0] model_vpn [40:47];

    always #(CLK_PERIOD/2) clk = ~clk;

    paired_tlb u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
        .lk_asid(lk_asid), .lk_acc(lk_acc),
        .rs_valid(rs_valid), .rs_pa(rs_pa), .rs_ca(rs_ca),
        .rs_fault(rs_fault), .rs_multi(rs_multi),
        .mg_valid(mg_valid), .mg_op(mg_op), .mg_idx(mg_idx),
        .mg_vpn(mg_vpn), .mg_asid(mg_asid), .mg_mask(mg_mask),
        .mg_lo0(mg_lo0), .mg_lo1(mg_lo1), .cfg_wired(cfg_wired),
        .mg_rvalid(mg_rvalid), .mg_ridx(mg_ridx), .mg_rvpn(mg_rvpn),
        .mg_rasid(mg_rasid), .mg_rmask(mg_rmask),
        .mg_rlo0(mg_rlo0), .mg_rlo1(mg_rlo1)
    );

    function automatic logic [35:0] rec(logic ncs, logic ncl, logic [27:0] pfn,
                                        logic [2:0] ca, logic d, logic v, logic g);
        return {ncs, ncl, pfn, ca, d, v, g};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc);
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_acc = acc;
        @(negedge clk);
        lk_valid = 1'b0;
        o_lat = 1;
        while (!rs_valid && o_lat < 8) begin
            @(negedge clk);
            o_lat++;
        end
        o_pa = rs_pa; o_ca = rs_ca; o_flt = rs_fault; o_multi = rs_multi;
    endtask

    task automatic mgmt(input logic [1:0] op, input logic [5:0] idx, input logic [18:0] vpn,
                        input logic [7:0] asid, input logic [11:0] mask,
                        input logic [35:0] lo0, input logic [35:0] lo1);
        @(negedge clk);
        mg_valid = 1'b1; mg_op = op; mg_idx = idx; mg_vpn = vpn;
        mg_asid = asid; mg_mask = mask; mg_lo0 = lo0; mg_lo1 = lo1;
        @(negedge clk);
        mg_valid = 1'b0;
        o_rv = mg_rvalid; o_ridx = mg_ridx; o_rvpn = mg_rvpn; o_rasid = mg_rasid;
        o_rmask = mg_rmask; o_rlo0 = mg_rlo0; o_rlo1 = mg_rlo1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 rs_valid", 64'(rs_valid), 64'd0);
        check("R1 mg_rvalid", 64'(mg_rvalid), 64'd0);
        check("R1 lk_ready", 64'(lk_ready), 64'd1);
        lookup(32'h0040_0123, 8'd5, 2'd0);
        check("R1 empty table miss", 64'(o_flt), 64'd1);
        check("R2 miss pa zero", 64'(o_pa), 64'd0);
    endtask

    task automatic t_basic;
        mgmt(2'd1, 6'd3, 19'h200, 8'd5, 12'h000,
             rec(0, 0, 28'h12345, 3'd3, 1, 1, 0), rec(0, 0, 28'h0ABCD, 3'd5, 0, 1, 0));
        lookup(32'h0040_0123, 8'd5, 2'd0);
        check("R2 even pa", 64'(o_pa), 64'h00_1234_5123);
        check("R2 even ca", 64'(o_ca), 64'd3);
        check("R2 fault none", 64'(o_flt), 64'd0);
        check("R9 search latency", 64'(o_lat), 64'd2);
        lookup(32'h0040_0123, 8'd5, 2'd0);
        check("R9 last-hit latency", 64'(o_lat), 64'd1);
        check("R9 last-hit pa", 64'(o_pa), 64'h00_1234_5123);
        lookup(32'h0040_1456, 8'd5, 2'd0);
        check("R4 odd pa", 64'(o_pa), 64'h00_0ABC_D456);
        check("R4 odd ca", 64'(o_ca), 64'd5);
        lookup(32'h0040_0123, 8'd6, 2'd0);
        check("R2 asid mismatch miss", 64'(o_flt), 64'd1);
        lookup(32'h0040_1456, 8'd5, 2'd1);
        check("R6 store clean page", 64'(o_flt), 64'd3);
        lookup(32'h0040_1456, 8'd5, 2'd3);
        check("R6 cap store clean page", 64'(o_flt), 64'd3);
        lookup(32'h0040_0456, 8'd5, 2'd1);
        check("R6 store dirty page ok", 64'(o_flt), 64'd0);
        mgmt(2'd0, 6'd3, '0, '0, '0, '0, '0);
        check("R12 read valid", 64'(o_rv), 64'd1);
        check("R12 read tag", 64'(o_rvpn), 64'h200);
        check("R12 read asid", 64'(o_rasid), 64'd5);
        check("R12 read lo0", 64'(o_rlo0), 64'(rec(0, 0, 28'h12345, 3'd3, 1, 1, 0)));
        check("R12 read lo1", 64'(o_rlo1), 64'(rec(0, 0, 28'h0ABCD, 3'd5, 0, 1, 0)));
    endtask

    task automatic t_global_perm;
        mgmt(2'd1, 6'd4, 19'h300, 8'd1, 12'h000,
             rec(0, 0, 28'h300, 3'd1, 1, 0, 1), rec(1, 1, 28'h301, 3'd4, 1, 1, 1));
        lookup(32'h0060_0040, 8'd9, 2'd0);
        check("R5 invalid record", 64'(o_flt), 64'd2);
        lookup(32'h0060_1040, 8'd9, 2'd0);
        check("R3 global any asid", 64'(o_flt), 64'd0);
        check("R3 global pa", 64'(o_pa), 64'h00_0030_1040);
        check("R7 plain load ignores ncl", 64'(o_ca), 64'd4);
        lookup(32'h0060_1040, 8'd9, 2'd2);
        check("R7 cap load fault", 64'(o_flt), 64'd4);
        lookup(32'h0060_1040, 8'd9, 2'd3);
        check("R7 cap store fault", 64'(o_flt), 64'd5);
        lookup(32'h0060_1040, 8'd9, 2'd1);
        check("R7 plain store ignores ncs", 64'(o_flt), 64'd0);
        mgmt(2'd1, 6'd5, 19'h380, 8'd1, 12'h000,
             rec(0, 0, 28'h380, 3'd0, 1, 1, 1), rec(0, 0, 28'h381, 3'd0, 1, 1, 0));
        lookup(32'h0070_0000, 8'd2, 2'd0);
        check("R3 half global needs asid", 64'(o_flt), 64'd1);
        lookup(32'h0070_0000, 8'd1, 2'd0);
        check("R3 half global own asid", 64'(o_flt), 64'd0);
    endtask

    task automatic t_mask;
        mgmt(2'd1, 6'd6, 19'h800, 8'd1, 12'h003,
             rec(0, 0, 28'h80, 3'd0, 1, 1, 0), rec(0, 0, 28'h40, 3'd6, 1, 1, 0));
        lookup(32'h0100_7ABC, 8'd1, 2'd0);
        check("R4 masked odd pa", 64'(o_pa), 64'h00_0004_3ABC);
        check("R4 masked odd ca", 64'(o_ca), 64'd6);
        lookup(32'h0100_2ABC, 8'd1, 2'd0);
        check("R4 masked even pa", 64'(o_pa), 64'h00_0008_2ABC);
        lookup(32'h0100_8000, 8'd1, 2'd0);
        check("R4 outside masked page", 64'(o_flt), 64'd1);
    endtask

    task automatic t_bypass;
        lookup(32'h8123_4567, 8'd0, 2'd3);
        check("R8 bypass pa", 64'(o_pa), 64'h00_0123_4567);
        check("R8 bypass ca", 64'(o_ca), 64'd2);
        check("R8 bypass no fault", 64'(o_flt), 64'd0);
        check("R8 bypass latency", 64'(o_lat), 64'd1);
    endtask

    task automatic t_clear;
        lookup(32'h0040_0123, 8'd5, 2'd0);
        lookup(32'h0040_0123, 8'd5, 2'd0);
        check("R10 warm latency", 64'(o_lat), 64'd1);
        mgmt(2'd1, 6'd10, 19'h2000, 8'd3, 12'h000,
             rec(0, 0, 28'h2000, 3'd0, 1, 1, 0), rec(0, 0, 28'h2001, 3'd0, 1, 1, 0));
        check("R12 write returns old tag", 64'(o_rvpn), 64'd0);
        check("R12 write echoes index", 64'(o_ridx), 64'd10);
        lookup(32'h0040_0123, 8'd5, 2'd0);
        check("R10 latency after write", 64'(o_lat), 64'd2);
        check("R10 pa after write", 64'(o_pa), 64'h00_1234_5123);
    endtask

    task automatic t_multi;
        mgmt(2'd1, 6'd7, 19'h1000, 8'd1, 12'h000,
             rec(0, 0, 28'h777, 3'd0, 1, 1, 0), rec(0, 0, 28'h778, 3'd0, 1, 1, 0));
        mgmt(2'd1, 6'd2, 19'h1000, 8'd1, 12'h000,
             rec(0, 0, 28'h222, 3'd1, 1, 1, 0), rec(0, 0, 28'h223, 3'd1, 1, 1, 0));
        lookup(32'h0200_0010, 8'd1, 2'd0);
        check("R11 lowest index wins", 64'(o_pa), 64'h00_0022_2010);
        check("R11 multi flag", 64'(o_multi), 64'd1);
        lookup(32'h0200_0010, 8'd1, 2'd0);
        check("R11 multi not cached", 64'(o_lat), 64'd2);
        check("R11 multi flag again", 64'(o_multi), 64'd1);
    endtask

    task automatic t_random;
        cfg_wired = 6'd40;
        for (int i = 40; i < 48; i++) begin
            mgmt(2'd1, 6'(i), 19'(32'h4000 + i), 8'd0, 12'h000, '0, '0);
            model_vpn[i] = 19'(32'h4000 + i);
        end
        for (int k = 0; k < 4; k++) begin
            repeat (k * 3 + 1) @(negedge clk);
            mgmt(2'd2, 6'd0, 19'(32'h5000 + k), 8'd0, 12'h000, '0, '0);
            check("R13 victim above wired", 64'(o_ridx >= 6'd40), 64'd1);
            check("R13 victim in table", 64'(o_ridx <= 6'd47), 64'd1);
            if (o_ridx >= 6'd40 && o_ridx <= 6'd47) begin
                check("R13 old contents", 64'(o_rvpn), 64'(model_vpn[o_ridx]));
                model_vpn[o_ridx] = 19'(32'h5000 + k);
                mgmt(2'd0, o_ridx, '0, '0, '0, '0, '0);
                check("R13 new contents stored", 64'(o_rvpn), 64'(32'h5000 + k));
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_global_perm();
        t_mask();
        t_bypass();
        t_clear();
        t_multi();
        t_random();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule